// File: doc/BRIEF.md
# Envelope-Midpoint FSK Bit Slicer

This block turns a stream of filtered, signed baseband samples from an FSK demodulator into hard data bits. It keeps two envelope detectors: one rides the top of the waveform and one rides the bottom. The decision level sits halfway between them. Each detector jumps at once to any sample beyond its current value. When no new extreme arrives, it eases back toward the signal by a shifted fraction of the gap, so the level adapts when the received amplitude changes.

Stale envelopes are the main hazard. When the receiver is switched on, or when the front end changes gain, the old extremes no longer describe the signal. For a set number of accepted samples after either event, both detectors copy the incoming sample and the output bit is frozen. Normal slicing then resumes from envelopes seeded by live data. The decay shift and the length of that settle window are parameters.

Top module: `peak_slicer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `bit_o` = 0, `bit_vld_o` = 0 and `thr_o` = 0.
- R2: The upper envelope never falls below the lower envelope. `thr_o` equals floor((upper + lower) / 2), computed with one guard bit, so it is exact at the full-scale extremes, for example upper = 2^(W-1)-1 and lower = -2^(W-1) give -1.
- R3: On an accepted sample outside tracking, a sample above the upper envelope replaces it, and a sample below the lower envelope replaces it. Both take effect at the next clock edge.
- R4: On an accepted sample outside tracking, an envelope that is not replaced moves toward the sample by (gap >> DECAY_SH), where gap is the absolute distance between the envelope and the sample.
- R5: A low-to-high change of `en_i` starts a tracking window of SETTLE accepted samples. During the window both envelopes load the sample, so `thr_o` equals that sample.
- R6: A one-cycle high pulse on `gain_step_i` also starts a tracking window of SETTLE accepted samples, with the same behaviour as in R5.
- R7: A sample is accepted when `smp_vld_i` and `en_i` are both high. One cycle later `bit_vld_o` pulses. Outside tracking, `bit_o` is then 1 if the sample was strictly greater than the `thr_o` value in force when the sample was presented, and 0 otherwise.
- R8: For a sample accepted while tracking, `bit_o` keeps its previous value.
- R9: While `en_i` is low, samples are ignored: `bit_vld_o` stays low and `thr_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Slicer enable; its rising edge arms the settle window |
| gain_step_i | input | 1 | One-cycle pulse when the front-end gain changes |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | W | Signed filtered baseband sample |
| bit_o | output | 1 | Sliced data bit |
| bit_vld_o | output | 1 | Pulses one cycle after each accepted sample |
| thr_o | output | W | Current decision threshold (envelope midpoint) |

## Verification
The assertions assume that `gain_step_i` is a single-cycle pulse and that `smp_i` is a legal two's-complement value of W bits. The decay and ordering checks also assume that the envelopes only start to diverge after a tracking window has seeded them. The stimulus follows this: every gain step is a one-cycle pulse with the sample strobe low, and enable changes happen on idle cycles. Samples include both full-scale extremes, so the midpoint guard bit is exercised. The envelope reference in the stimulus applies the same attack, decay and tracking rules to predict every bit and every threshold.

// File: rtl/pkslice_pkg.sv
package pkslice_pkg;

    // Which envelope a detector follows
    typedef enum logic {
        ENV_UPPER = 1'b0,
        ENV_LOWER = 1'b1
    } env_kind_e;

    // Per-cycle instruction to a detector
    typedef struct packed {
        logic seed;    // copy the sample (tracking)
        logic step;    // attack or decay (normal)
    } env_cmd_t;

    // Width of a down-counter that holds 0..n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/settle_ctl.sv
module settle_ctl
    import pkslice_pkg::*;
#(
    parameter int SETTLE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic gain_step_i,
    input  logic smp_vld_i,
    output logic accept_o,
    output logic track_o
);
    localparam int CW = cnt_width(SETTLE);

    logic          en_q;
    logic [CW-1:0] remain;
    logic          arm;

    assign accept_o = smp_vld_i & en_i;
    assign arm      = (en_i & ~en_q) | gain_step_i;
    assign track_o  = arm | (remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            remain <= '0;
        end else begin
            en_q <= en_i;
            if (arm)
                remain <= accept_o ? CW'(SETTLE - 1) : CW'(SETTLE);
            else if (accept_o && remain != '0)
                remain <= remain - 1'b1;
        end
    end

    AST_SETTLE_ARM: assert property (@(posedge clk) disable iff (rst)
        (arm && !accept_o) |=> (remain == CW'(SETTLE)));                // R5
    AST_SETTLE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!arm && accept_o && remain != '0) |=> (remain == $past(remain) - 1'b1)); // R6

endmodule

// File: rtl/env_det.sv
module env_det
    import pkslice_pkg::*;
#(
    parameter int        W        = 12,
    parameter int        DECAY_SH = 4,
    parameter env_kind_e KIND     = ENV_UPPER
) (
    input  logic                clk,
    input  logic                rst,
    input  env_cmd_t            cmd_i,
    input  logic signed [W-1:0] smp_i,
    output logic signed [W-1:0] env_o
);
    logic signed [W:0]   gap;     // distance the envelope lies beyond the sample
    logic signed [W:0]   nudge;
    logic                overtake;
    logic signed [W:0]   moved;

    generate
        if (KIND == ENV_UPPER) begin : g_upper
            assign gap   = $signed({env_o[W-1], env_o}) - $signed({smp_i[W-1], smp_i});
            assign moved = $signed({env_o[W-1], env_o}) - nudge;
        end else begin : g_lower
            assign gap   = $signed({smp_i[W-1], smp_i}) - $signed({env_o[W-1], env_o});
            assign moved = $signed({env_o[W-1], env_o}) + nudge;
        end
    endgenerate

    assign overtake = gap[W];          // sample lies beyond the envelope
    assign nudge    = gap >>> DECAY_SH;

    always_ff @(posedge clk) begin
        if (rst)
            env_o <= '0;
        else if (cmd_i.seed)
            env_o <= smp_i;
        else if (cmd_i.step)
            env_o <= overtake ? smp_i : moved[W-1:0];
    end

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
        cmd_i.seed |=> (env_o == $past(smp_i)));                        // R5
    AST_ATTACK: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.step && !cmd_i.seed && overtake) |=> (env_o == $past(smp_i))); // R3
    AST_DECAY_UP: assert property (@(posedge clk) disable iff (rst)
        (KIND == ENV_UPPER && cmd_i.step && !cmd_i.seed && !overtake)
        |=> (env_o <= $past(env_o) && env_o >= $past(smp_i)));          // R4
    AST_DECAY_LO: assert property (@(posedge clk) disable iff (rst)
        (KIND == ENV_LOWER && cmd_i.step && !cmd_i.seed && !overtake)
        |=> (env_o >= $past(env_o) && env_o <= $past(smp_i)));          // R4

endmodule

// File: rtl/slice_dec.sv
module slice_dec #(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept_i,
    input  logic                track_i,
    input  logic signed [W-1:0] smp_i,
    input  logic signed [W-1:0] hi_i,
    input  logic signed [W-1:0] lo_i,
    output logic signed [W-1:0] thr_o,
    output logic                bit_o,
    output logic                bit_vld_o
);
    logic signed [W:0] sum;

    assign sum   = $signed({hi_i[W-1], hi_i}) + $signed({lo_i[W-1], lo_i});
    assign thr_o = sum[W:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_o     <= 1'b0;
            bit_vld_o <= 1'b0;
        end else begin
            bit_vld_o <= accept_i;
            if (accept_i && !track_i)
                bit_o <= (smp_i > thr_o);
        end
    end

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (accept_i && track_i) |=> $stable(bit_o));                      // R8
    AST_STROBE: assert property (@(posedge clk) disable iff (rst)
        accept_i |=> bit_vld_o);                                        // R7
    AST_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !accept_i |=> !bit_vld_o);                                      // R9

endmodule

// File: rtl/peak_slicer.sv
module peak_slicer
    import pkslice_pkg::*;
#(
    parameter int W        = 12,
    parameter int DECAY_SH = 4,
    parameter int SETTLE   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic                gain_step_i,
    input  logic                smp_vld_i,
    input  logic signed [W-1:0] smp_i,
    output logic                bit_o,
    output logic                bit_vld_o,
    output logic signed [W-1:0] thr_o
);
    logic                accept;
    logic                track;
    env_cmd_t            cmd;
    logic signed [W-1:0] env_hi;
    logic signed [W-1:0] env_lo;

    assign cmd.seed = accept & track;
    assign cmd.step = accept & ~track;

    settle_ctl #(.SETTLE(SETTLE)) u_settle (
        .clk(clk), .rst(rst), .en_i(en_i), .gain_step_i(gain_step_i),
        .smp_vld_i(smp_vld_i), .accept_o(accept), .track_o(track)
    );

    env_det #(.W(W), .DECAY_SH(DECAY_SH), .KIND(ENV_UPPER)) u_hi (
        .clk(clk), .rst(rst), .cmd_i(cmd), .smp_i(smp_i), .env_o(env_hi)
    );

    env_det #(.W(W), .DECAY_SH(DECAY_SH), .KIND(ENV_LOWER)) u_lo (
        .clk(clk), .rst(rst), .cmd_i(cmd), .smp_i(smp_i), .env_o(env_lo)
    );

    slice_dec #(.W(W)) u_dec (
        .clk(clk), .rst(rst), .accept_i(accept), .track_i(track),
        .smp_i(smp_i), .hi_i(env_hi), .lo_i(env_lo),
        .thr_o(thr_o), .bit_o(bit_o), .bit_vld_o(bit_vld_o)
    );

    AST_ENV_ORDER: assert property (@(posedge clk) disable iff (rst)
        env_hi >= env_lo);                                              // R2
    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> ($stable(env_hi) && $stable(env_lo)));                // R9

endmodule

// File: tb/sim_peak_slicer.sv
module sim_peak_slicer;
    localparam int CLK_P  = 10;
    localparam int W      = 12;
    localparam int DSH    = 2;
    localparam int SETTLE = 4;
    localparam int WD_CYC = 20000;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                en = 1'b0;
    logic                gstep = 1'b0;
    logic                vld = 1'b0;
    logic signed [W-1:0] smp = '0;
    logic                bit_o;
    logic                bit_vld;
    logic signed [W-1:0] thr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int    q_bit[$];
    int    q_thr[$];
    string q_tag[$];

    // reference state
    int m_hi = 0, m_lo = 0, m_cnt = 0, m_bit = 0;
    bit m_en = 1'b0;

    peak_slicer #(.W(W), .DECAY_SH(DSH), .SETTLE(SETTLE)) u0 (
        .clk(clk), .rst(rst), .en_i(en), .gain_step_i(gstep),
        .smp_vld_i(vld), .smp_i(smp),
        .bit_o(bit_o), .bit_vld_o(bit_vld), .thr_o(thr)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int mid(int a, int b);
        return (a + b) >>> 1;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: presents one sample and pushes the predicted result
    task automatic send(int s, string tag);
        int t;
        @(negedge clk);
        vld = 1'b1;
        smp = W'(s);
        if (!m_en) return;
        t = mid(m_hi, m_lo);
        if (m_cnt > 0) begin
            m_hi = s; m_lo = s; m_cnt--;
        end else begin
            m_bit = (s > t) ? 1 : 0;
            if (s > m_hi) m_hi = s; else m_hi = m_hi - ((m_hi - s) >> DSH);
            if (s < m_lo) m_lo = s; else m_lo = m_lo + ((s - m_lo) >> DSH);
        end
        q_bit.push_back(m_bit);
        q_thr.push_back(mid(m_hi, m_lo));
        q_tag.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vld = 1'b0;
        end
    endtask

    task automatic set_en(bit v);
        @(negedge clk);
        vld = 1'b0;
        if (v && !m_en) m_cnt = SETTLE;
        en = v;
        m_en = v;
    endtask

    task automatic gain_pulse();
        @(negedge clk);
        vld = 1'b0;
        gstep = 1'b1;
        m_cnt = SETTLE;
        @(negedge clk);
        gstep = 1'b0;
    endtask

    // monitor: pops and compares each produced bit
    always @(posedge clk) begin
        #(CLK_P/4);
        if (!rst && bit_vld) begin
            if (q_bit.size() == 0) begin
                check("R9 unexpected bit_vld", 1, 0);
            end else begin
                string tg;
                int eb, et;
                tg = q_tag.pop_front();
                eb = q_bit.pop_front();
                et = q_thr.pop_front();
                check({tg, " bit"}, int'(bit_o), eb);
                check({tg, " thr"}, int'(thr), et);
            end
        end
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 bit_o in reset", int'(bit_o), 0);
        check("R1 bit_vld in reset", int'(bit_vld), 0);
        check("R1 thr in reset", int'(thr), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 bit_o after reset", int'(bit_o), 0);
        check("R1 thr after reset", int'(thr), 0);

        // R5: settle window after enable rises, threshold follows sample, bit held (R8)
        set_en(1'b1);
        send(100, "R5"); send(-50, "R5"); send(30, "R8"); send(7, "R8");

        // R7 / R3: square wave, envelopes attack then slice
        for (int i = 0; i < 6; i++) begin
            send(400, "R3"); send(-400, "R7");
        end
        send(50, "R7"); send(-20, "R7");
        // R4: amplitude drops, envelopes decay
        for (int i = 0; i < 8; i++) begin
            send(120, "R4"); send(-120, "R4");
        end
        idle(2);

        // R2: full-scale extremes, guard bit keeps midpoint exact
        send(2047, "R2"); send(-2048, "R2"); send(0, "R2"); send(-1, "R2");
        idle(2);

        // R6: gain step re-seeds both envelopes
        gain_pulse();
        send(300, "R6"); send(-10, "R6"); send(60, "R6"); send(-200, "R6");
        send(250, "R7"); send(-250, "R7"); send(90, "R4");
        idle(2);

        // R9: samples ignored while disabled
        set_en(1'b0);
        send(1500, "R9"); send(-1500, "R9"); send(999, "R9");
        idle(2);
        check("R9 thr frozen", int'(thr), mid(m_hi, m_lo));

        // R5 again after re-enable
        set_en(1'b1);
        send(-75, "R5"); send(-75, "R5"); send(10, "R5"); send(-30, "R5");
        send(200, "R7"); send(-200, "R7");
        idle(4);

        check("R7 queue drained", q_bit.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule